// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block is the slave side of a serial programming port. Over a mode-0 SPI link it takes in command packets. A packet opens when slave-select falls and closes when it rises. Every packet starts with a fixed two-byte preamble. An opcode, a 16-bit address and one or more data bytes follow. Page-write data goes into an internal page buffer of `PAGE_BYTES` entries. Page reads stream bytes back out of that buffer. Signature and status bytes are returned on MISO.

The decoder answers only while the device-reset qualifier is held low. Closing a page-write packet starts a fixed busy interval. In its first cycles, the bytes loaded by that packet are written out to a memory through a simple write port. All SPI inputs are sampled by the fast system clock through synchronisers, so SCK must run well below that clock; the link is rated to 5 MHz.

Opcodes: `50h` page write, `30h` page read, `38h` signature read, `60h` status read. Any other opcode is accepted and answered with `00h`.

Top module: `prog_cmd_decoder`

## Requirements
- R1: SPI mode 0. MOSI is captured on rising SCK and MISO changes only after falling SCK. Bytes travel most significant bit first in both directions.
- R2: While `dev_rst_n` is high, all SPI activity is ignored. `miso_oe` stays 0, no memory write occurs, and the page buffer is left unchanged.
- R3: If the first byte is not AAh or the second is not 55h, the rest of the packet is discarded. Its response bytes are 00h and it causes no write. The decoder re-arms at the next slave-select fall.
- R4: Signature read (`38h`) returns 1Eh, 29h and FFh for address low byte 00h, 01h and 02h. It returns 00h for any other offset.
- R5: Page write (`50h`) places data bytes in the page buffer. The first byte goes to the offset in address bits 4:0, and the page number comes from address bits 10:5. `mem_addr` is {page, offset}. When slave-select rises, exactly the offsets loaded by that packet are written to memory.
- R6: Each data byte advances the offset. The offset wraps from 31 to 0 inside the same page.
- R7: Closing a page-write packet starts a busy interval of `BUSY_CYCLES` clocks. A status read (`60h`) returns 01h during that interval and 00h afterwards.
- R8: Page read (`30h`) returns buffer bytes starting at the addressed offset, advancing and wrapping as in R6.
- R9: `miso_oe` is 0 whenever slave-select is high. The response bytes for the preamble, opcode and address are 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low block reset |
| dev_rst_n | input | 1 | Device reset qualifier; commands honoured only while low |
| sck | input | 1 | SPI clock, idle low |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO (tristate model) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |

## Verification
A table of single-byte commands covers all three signature offsets and an out-of-range offset. Because the values are asymmetric, they separate a correct MSB-first shifter from a reversed or shifted one. The table also includes an idle status read and an unknown opcode, which separate the response multiplexer's legs. Directed packets cover three cases. One writes a mid-page run, which shows that only the loaded offsets reach memory and the page split is right. One writes across offset 31, which shows the wrap stays within the page. One reads back across the same wrap. Last come a corrupted preamble followed by a good packet, and a full write sent with the qualifier high. These show that dropping, re-arming and gating each leave memory and buffer untouched.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

    typedef enum logic [2:0] {
        PH_PRE1,
        PH_PRE2,
        PH_OPC,
        PH_AHI,
        PH_ALO,
        PH_DATA,
        PH_DROP
    } phase_e;

    localparam logic [7:0] PREAMBLE_A = 8'hAA;
    localparam logic [7:0] PREAMBLE_B = 8'h55;

    localparam logic [7:0] OP_PAGE_WR = 8'h50;
    localparam logic [7:0] OP_PAGE_RD = 8'h30;
    localparam logic [7:0] OP_SIG_RD  = 8'h38;
    localparam logic [7:0] OP_STATUS  = 8'h60;

    function automatic logic [7:0] sig_byte(input logic [7:0] ofs);
        case (ofs)
            8'h00:   sig_byte = 8'h1E;
            8'h01:   sig_byte = 8'h29;
            8'h02:   sig_byte = 8'hFF;
            default: sig_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/prog_spi_sync.sv
module prog_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic ss_n,
    input  logic dev_rst_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic ss_rise,
    output logic ss_fall,
    output logic mosi_s,
    output logic ss_s,
    output logic dev_s
);
    // lane order: 0 sck, 1 mosi, 2 ss_n, 3 dev_rst_n
    localparam int LANES = 4;
    localparam logic [LANES-1:0] IDLE_VAL = 4'b1100;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] chain_q [SYNC_STAGES];
    logic             sck_prev_q;
    logic             ss_prev_q;

    assign raw = {dev_rst_n, ss_n, mosi, sck};

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain_q[s] <= IDLE_VAL;
            else if (s == 0)
                chain_q[s] <= raw;
            else
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            ss_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= chain_q[SYNC_STAGES-1][0];
            ss_prev_q  <= chain_q[SYNC_STAGES-1][2];
        end
    end

    assign mosi_s   = chain_q[SYNC_STAGES-1][1];
    assign ss_s     = chain_q[SYNC_STAGES-1][2];
    assign dev_s    = chain_q[SYNC_STAGES-1][3];
    assign sck_rise = chain_q[SYNC_STAGES-1][0] & ~sck_prev_q;
    assign sck_fall = ~chain_q[SYNC_STAGES-1][0] & sck_prev_q;
    assign ss_rise  = chain_q[SYNC_STAGES-1][2] & ~ss_prev_q;
    assign ss_fall  = ~chain_q[SYNC_STAGES-1][2] & ss_prev_q;

endmodule

// File: rtl/prog_busy_drain.sv
module prog_busy_drain #(
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [PAGE_BYTES-1:0]         mask,
    output logic                          busy,
    output logic                          drain_we,
    output logic [$clog2(PAGE_BYTES)-1:0] drain_ofs
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam int IDX_W = $clog2(PAGE_BYTES + 1);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } busy_t;

    busy_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.idx < IDX_W'(PAGE_BYTES))
                d.idx = q.idx + 1'b1;
        end else if (start) begin
            d.cnt = CNT_W'(BUSY_CYCLES);
            d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.idx <= IDX_W'(PAGE_BYTES);
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.cnt != '0);
    assign drain_ofs = q.idx[OFS_W-1:0];
    assign drain_we  = busy && (q.idx < IDX_W'(PAGE_BYTES)) && mask[drain_ofs];

    assert_busy_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) |=> (q.cnt == $past(q.cnt) - 1'b1))
        else $error("busy counter did not count down");

endmodule

// File: rtl/prog_cmd_decoder.sv
module prog_cmd_decoder #(
    parameter int PAGE_BYTES  = 32,
    parameter int PAGE_W      = 6,
    parameter int BUSY_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     dev_rst_n,
    input  logic                                     sck,
    input  logic                                     mosi,
    input  logic                                     ss_n,
    output logic                                     miso,
    output logic                                     miso_oe,
    output logic                                     mem_we,
    output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0]     mem_addr,
    output logic [7:0]                               mem_wdata
);
    import prog_cmd_pkg::*;

    localparam int OFS_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e                         phase;
        logic [2:0]                     bitn;
        logic [7:0]                     sh;
        logic [7:0]                     op;
        logic [7:0]                     ahi;
        logic [7:0]                     alo;
        logic [PAGE_W-1:0]              page;
        logic [OFS_W-1:0]               ofs;
        logic [PAGE_BYTES-1:0]          mask;
        logic [PAGE_BYTES-1:0][7:0]     pbuf;
        logic [7:0]                     tx;
        logic                           oe;
    } ctl_t;

    ctl_t q, d;

    logic sck_rise, sck_fall, ss_rise, ss_fall, mosi_s, ss_s, dev_s;
    logic active, byte_done, start, busy, drain_we;
    logic [OFS_W-1:0] drain_ofs;
    logic [7:0] rx_byte, resp;
    logic [15:0] addr16;

    prog_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .dev_rst_n(dev_rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .ss_rise(ss_rise), .ss_fall(ss_fall), .mosi_s(mosi_s),
        .ss_s(ss_s), .dev_s(dev_s)
    );

    prog_busy_drain #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .mask(q.mask),
        .busy(busy), .drain_we(drain_we), .drain_ofs(drain_ofs)
    );

    assign active    = !ss_s && !dev_s;
    assign rx_byte   = {q.sh[6:0], mosi_s};
    assign byte_done = active && !ss_fall && sck_rise && (q.bitn == 3'd7);
    assign addr16    = {q.ahi, rx_byte};

    always_comb begin
        resp = 8'h00;
        if (q.phase == PH_DATA) begin
            case (q.op)
                OP_PAGE_RD: resp = q.pbuf[q.ofs];
                OP_SIG_RD:  resp = sig_byte(q.alo);
                OP_STATUS:  resp = {7'b0, busy};
                default:    resp = 8'h00;
            endcase
        end
    end

    always_comb begin
        d     = q;
        start = ss_rise && !dev_s && (q.phase == PH_DATA) &&
                (q.op == OP_PAGE_WR) && (q.mask != '0);
        d.oe  = active;
        if (!active || ss_fall) begin
            d.bitn  = '0;
            d.phase = PH_PRE1;
            d.tx    = '0;
        end else begin
            if (sck_rise) begin
                d.sh   = rx_byte;
                d.bitn = q.bitn + 1'b1;
                if (q.bitn == 3'd7) begin
                    case (q.phase)
                        PH_PRE1: d.phase = (rx_byte == PREAMBLE_A) ? PH_PRE2 : PH_DROP;
                        PH_PRE2: d.phase = (rx_byte == PREAMBLE_B) ? PH_OPC : PH_DROP;
                        PH_OPC: begin
                            d.op    = rx_byte;
                            d.phase = PH_AHI;
                        end
                        PH_AHI: begin
                            d.ahi   = rx_byte;
                            d.phase = PH_ALO;
                        end
                        PH_ALO: begin
                            d.alo   = rx_byte;
                            d.page  = addr16[OFS_W +: PAGE_W];
                            d.ofs   = rx_byte[OFS_W-1:0];
                            d.phase = PH_DATA;
                            if (q.op == OP_PAGE_WR)
                                d.mask = '0;
                        end
                        PH_DATA: begin
                            if (q.op == OP_PAGE_WR) begin
                                d.pbuf[q.ofs] = rx_byte;
                                d.mask[q.ofs] = 1'b1;
                            end
                            d.ofs = q.ofs + 1'b1;
                        end
                        default: d.phase = q.phase;
                    endcase
                end
            end
            if (sck_fall) begin
                if (q.bitn == 3'd0)
                    d.tx = resp;
                else
                    d.tx = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_PRE1;
        end else begin
            q <= d;
        end
    end

    assign miso      = q.tx[7];
    assign miso_oe   = q.oe;
    assign mem_we    = drain_we;
    assign mem_addr  = {q.page, drain_ofs};
    assign mem_wdata = q.pbuf[drain_ofs];

    assert_tx_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ss_fall && !sck_fall) |=> $stable(q.tx))
        else $error("MISO shifter moved without a falling SCK");

    assert_oe_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_s |=> !miso_oe)
        else $error("MISO enabled while device reset released");

    assert_drop_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DROP && active && !ss_fall) |=> (q.phase == PH_DROP))
        else $error("dropped packet re-armed before slave-select rose");

    assert_offset_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && q.phase == PH_DATA && q.ofs == '1) |=> (q.ofs == '0))
        else $error("offset did not wrap to zero");

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("page write close did not raise busy");

    assert_oe_ss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !miso_oe)
        else $error("MISO enabled while slave-select high");

endmodule

// File: tb/prog_cmd_decoder_test.sv
module prog_cmd_decoder_test;

    localparam int HALF = 20;
    localparam int BUSY = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_rst_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic ss_n = 1'b1;
    logic miso, miso_oe, mem_we;
    logic [10:0] mem_addr;
    logic [7:0] mem_wdata;

    always #2.5 clk = ~clk;

    prog_cmd_decoder #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .sck(sck), .mosi(mosi),
        .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mem [2048];
    int wr_count = 0;
    bit oe_watch = 1'b0;
    bit oe_seen = 1'b0;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (oe_watch && miso_oe) oe_seen <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [7:0] txb [8];
    logic [7:0] rxb [8];

    task automatic spi_byte(input int k);
        for (int i = 7; i >= 0; i--) begin
            mosi = txb[k][i];
            wait_clk(HALF);
            rxb[k][i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic run_pkt(input int n);
        ss_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) spi_byte(k);
        wait_clk(HALF);
        ss_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic hdr(input logic [7:0] op, input logic [7:0] ah, input logic [7:0] al);
        txb[0] = 8'hAA; txb[1] = 8'h55; txb[2] = op; txb[3] = ah; txb[4] = al;
        for (int k = 5; k < 8; k++) txb[k] = 8'h00;
    endtask

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] ahi;
        logic [7:0] alo;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h38, 8'h00, 8'h00, 8'h1E},
        '{8'h38, 8'h00, 8'h01, 8'h29},
        '{8'h38, 8'h00, 8'h02, 8'hFF},
        '{8'h38, 8'h00, 8'h03, 8'h00},
        '{8'h60, 8'h00, 8'h00, 8'h00},
        '{8'h77, 8'h00, 8'h00, 8'h00}
    };

    initial begin
        int wc;
        wait_clk(10);
        // reset state
        check(miso_oe == 1'b0, "R9 reset oe", miso_oe, 0);
        check(mem_we == 1'b0, "R5 reset we", mem_we, 0);
        rst_n = 1'b1;
        wait_clk(10);
        dev_rst_n = 1'b0;
        wait_clk(10);
        check(miso_oe == 1'b0, "R9 oe with ss high", miso_oe, 0);

        // table: R4 signature, R1 MSB-first, status idle, unknown opcode
        for (int v = 0; v < 6; v++) begin
            hdr(VECS[v].op, VECS[v].ahi, VECS[v].alo);
            run_pkt(6);
            check(rxb[5] == VECS[v].exp, "R4/R1 table response", rxb[5], VECS[v].exp);
        end

        // R9: header response bytes are zero and oe high inside packet
        hdr(8'h38, 8'h00, 8'h00);
        ss_n = 1'b0;
        wait_clk(HALF);
        check(miso_oe == 1'b1, "R9 oe in packet", miso_oe, 1);
        for (int k = 0; k < 6; k++) spi_byte(k);
        ss_n = 1'b1;
        wait_clk(HALF);
        check(rxb[0] == 0 && rxb[2] == 0 && rxb[4] == 0, "R9 header bytes zero", rxb[4], 0);

        // R5: page write at 0x0123 -> page 9, offset 3
        wc = wr_count;
        hdr(8'h50, 8'h01, 8'h23);
        txb[5] = 8'hA1; txb[6] = 8'hB2; txb[7] = 8'hC3;
        run_pkt(8);
        // R7: status read while busy
        hdr(8'h60, 8'h00, 8'h00);
        run_pkt(6);
        check(rxb[5] == 8'h01, "R7 status busy", rxb[5], 8'h01);
        check(mem[9*32+3] == 8'hA1, "R5 byte0", mem[9*32+3], 8'hA1);
        check(mem[9*32+4] == 8'hB2, "R5 byte1", mem[9*32+4], 8'hB2);
        check(mem[9*32+5] == 8'hC3, "R5 byte2", mem[9*32+5], 8'hC3);
        check(wr_count - wc == 3, "R5 write count", wr_count - wc, 3);
        wait_clk(BUSY + 100);
        hdr(8'h60, 8'h00, 8'h00);
        run_pkt(6);
        check(rxb[5] == 8'h00, "R7 status idle", rxb[5], 8'h00);

        // R6: wrap 30,31,0 within page 2
        wc = wr_count;
        hdr(8'h50, 8'h00, 8'h5E);
        txb[5] = 8'h11; txb[6] = 8'h22; txb[7] = 8'h33;
        run_pkt(8);
        wait_clk(100);
        check(mem[8'h5E] == 8'h11, "R6 ofs30", mem[8'h5E], 8'h11);
        check(mem[8'h5F] == 8'h22, "R6 ofs31", mem[8'h5F], 8'h22);
        check(mem[8'h40] == 8'h33, "R6 wrap ofs0", mem[8'h40], 8'h33);
        check(mem[8'h60] == 8'h00, "R6 next page untouched", mem[8'h60], 0);
        check(wr_count - wc == 3, "R6 write count", wr_count - wc, 3);
        wait_clk(BUSY + 100);

        // R8: page read across wrap
        hdr(8'h30, 8'h00, 8'h5F);
        run_pkt(7);
        check(rxb[5] == 8'h22, "R8 read ofs31", rxb[5], 8'h22);
        check(rxb[6] == 8'h33, "R8 read wrap ofs0", rxb[6], 8'h33);

        // R3: corrupted preamble, then re-arm
        wc = wr_count;
        hdr(8'h50, 8'h00, 8'h00);
        txb[1] = 8'h56; txb[5] = 8'h77;
        run_pkt(6);
        wait_clk(100);
        check(wr_count == wc, "R3 no write", wr_count - wc, 0);
        check(rxb[5] == 8'h00, "R3 zero response", rxb[5], 0);
        hdr(8'h30, 8'h00, 8'h40);
        run_pkt(6);
        check(rxb[5] == 8'h33, "R3 buffer kept / re-arm", rxb[5], 8'h33);

        // R2: qualifier high, full write ignored
        dev_rst_n = 1'b1;
        wait_clk(10);
        oe_watch = 1'b1;
        wc = wr_count;
        hdr(8'h50, 8'h00, 8'h40);
        txb[5] = 8'h5A;
        run_pkt(6);
        wait_clk(100);
        oe_watch = 1'b0;
        check(!oe_seen, "R2 oe stayed low", oe_seen, 0);
        check(wr_count == wc, "R2 no write", wr_count - wc, 0);
        dev_rst_n = 1'b0;
        wait_clk(10);
        hdr(8'h30, 8'h00, 8'h40);
        run_pkt(6);
        check(rxb[5] == 8'h33, "R2 buffer unchanged", rxb[5], 8'h33);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule